// File: doc/BRIEF.md
# Storage Host Port Register File

This block is the register model of a single serial storage host port. Software reaches it over a plain 32-bit register bus with a write strobe and a byte address. Reads are combinational and writes take effect at the clock edge. Inside the block sit several registers:

- interrupt status and interrupt enable;
- a command/status register with two engine controls, one for the command list and one for frame reception;
- a task-file view and a link-status view;
- a write-one-to-clear link error register;
- a command-issue register.

Each engine has a software enable bit and a hardware running bit. The running bit follows the enable bit, in both directions, after a configurable number of cycles. Software is expected to poll the running bit until it matches. Enable writes that break the start/stop ordering rules are discarded, and a sticky violation flag is raised. Hardware event inputs set status bits. An interrupt line is driven from the enabled pending bits and gated by a global enable. Two further outputs are derived from the register contents: a device-present flag and an error summary.

Top module: `stor_port_regs`

## Requirements
- R1: After reset every writable and write-one-to-clear register reads 0, and `irq_o` and `proto_viol_o` are 0.
- R2: Interrupt status (offset 0x10) sets from `evt_i` and clears where software writes a 1. An event arriving in the same cycle as a clear of that bit wins. Only the bits in mask 0xFDC000FF exist; all other bits read 0.
- R3: Interrupt enable (offset 0x14) is read/write within mask 0xFDC000FF. A source whose enable is 0 is still recorded in interrupt status.
- R4: `irq_o` is 1 exactly when `gie_i` is 1 and some bit is set in both status and enable.
- R5: Command/status (offset 0x18) has the following fields:
  - bit 0: command engine start (read/write);
  - bit 4: frame-receive enable (read/write);
  - bit 15: command engine running (read-only);
  - bit 14: frame-receive running (read-only);
  - bits 12:8: `cur_slot_i`, zero-extended.
  All other bits read 0 and ignore writes.
- R6: Each running bit takes the value of its enable bit exactly RUN_DELAY clock edges after the edge at which the enable bit changed. This holds for rising and falling changes. A running bit never changes while it already equals its enable bit.
- R7: A write that would raise start is ignored as a whole unless, before the write, frame-receive enable is 1 and command running is 0. Such a write sets `proto_viol_o`, which then stays 1 until reset.
- R8: A write that would clear frame-receive enable is ignored as a whole unless, before the write, start and command running are both 0. Such a write also sets `proto_viol_o`.
- R9: `err_sum_o` is the OR of interrupt status bits 30, 29, 28, 27, 26 and 24.
- R10: `dev_present_o` is 1 when both conditions below hold, and 0 otherwise:
  - `tfd_i[7]` and `tfd_i[3]` are both 0;
  - either `lstat_i[3:0]` equals 3, or `lstat_i[11:8]` is 2, 6 or 8.
- R11: Offset 0x20 reads `tfd_i` in bits 15:0, and offset 0x28 reads `lstat_i` in bits 11:0. Both are read-only, and writes to them have no effect.
- R12: Link error (offset 0x30) sets from `lerr_set_i` and clears where software writes a 1. Only the bits in mask 0x07FF0F03 exist.
- R13: Command issue (offset 0x38) sets where software writes a 1 and clears where `ci_done_i` is 1; a write of 0 has no effect. Only the low NSLOT bits exist.
- R14: Any offset that is not mapped, including unaligned addresses, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| evt_i | input | 32 | Hardware events that set interrupt status bits |
| lerr_set_i | input | 32 | Hardware events that set link error bits |
| tfd_i | input | 16 | Task-file value from the device side |
| lstat_i | input | 12 | Link status (power state in 11:8, detect in 3:0) |
| cur_slot_i | input | SLOT_W | Current command slot |
| ci_done_i | input | NSLOT | Per-slot command completion clears |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| dev_present_o | output | 1 | Device-present flag |
| err_sum_o | output | 1 | Error summary |
| proto_viol_o | output | 1 | Sticky start/stop protocol violation |

## Verification
The bench builds the block with RUN_DELAY = 3 and NSLOT = 8. With the short delay, the bench can observe the last cycle before each running bit flips and the cycle in which it flips. It can also issue a second enable write while a running bit is still settling, which is the window where R7 and R8 reject writes. With 8 slots, the bench can check that command-issue bits above the slot count read as zero.

// File: rtl/stor_port_pkg.sv
package stor_port_pkg;

  localparam int REG_AW = 7;

  localparam logic [REG_AW-1:0] OFS_ISTAT = 7'h10;
  localparam logic [REG_AW-1:0] OFS_IEN   = 7'h14;
  localparam logic [REG_AW-1:0] OFS_CMD   = 7'h18;
  localparam logic [REG_AW-1:0] OFS_TFD   = 7'h20;
  localparam logic [REG_AW-1:0] OFS_LSTAT = 7'h28;
  localparam logic [REG_AW-1:0] OFS_LERR  = 7'h30;
  localparam logic [REG_AW-1:0] OFS_CI    = 7'h38;

  localparam logic [31:0] IRQ_MASK  = 32'hFDC0_00FF;
  localparam logic [31:0] LERR_MASK = 32'h07FF_0F03;
  localparam logic [31:0] ERR_MASK  = 32'h7D00_0000;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_FRXEN_BIT = 4;
  localparam int CMD_SLOT_LSB  = 8;
  localparam int CMD_FRXRUN_BIT = 14;
  localparam int CMD_CMDRUN_BIT = 15;

  // Error summary over the fatal/error status sources.
  function automatic logic f_err_any(input logic [31:0] stat);
    return |(stat & ERR_MASK);
  endfunction

  // Device present: idle task file and a live link.
  function automatic logic f_dev_present(input logic [15:0] tfd,
                                         input logic [11:0] lst);
    logic idle_tf;
    logic link_up;
    idle_tf = !tfd[7] && !tfd[3];
    link_up = (lst[3:0] == 4'd3) || (lst[11:8] == 4'd2) ||
              (lst[11:8] == 4'd6) || (lst[11:8] == 4'd8);
    return idle_tf && link_up;
  endfunction

endpackage

// File: rtl/stor_run_track.sv
// Running indicator that follows its enable after DELAY stable edges.
module stor_run_track #(
  parameter int DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic run_o
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          mismatch;
  logic          expire;

  assign mismatch = (en_i != run_q);
  assign expire   = (cnt_q == CW'(DELAY - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!mismatch) begin
      cnt_q <= '0;
    end else if (expire) begin
      cnt_q <= '0;
      run_q <= en_i;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/stor_w1c_reg.sv
// Masked write-one-to-clear register, hardware set has priority.
module stor_w1c_reg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= ((q_r & ~clr_i) | set_i) & MASK;
  end

  assign q_o = q_r;
endmodule

// File: rtl/stor_port_regs.sv
module stor_port_regs
  import stor_port_pkg::*;
#(
  parameter int RUN_DELAY = 4,
  parameter int NSLOT     = 32,
  localparam int SLOT_W   = (NSLOT < 2) ? 1 : $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       evt_i,
  input  logic [31:0]       lerr_set_i,
  input  logic [15:0]       tfd_i,
  input  logic [11:0]       lstat_i,
  input  logic [SLOT_W-1:0] cur_slot_i,
  input  logic [NSLOT-1:0]  ci_done_i,
  input  logic              gie_i,
  output logic              irq_o,
  output logic              dev_present_o,
  output logic              err_sum_o,
  output logic              proto_viol_o
);
  localparam int NENG = 2;

  // Write decode
  logic wr_is, wr_ie, wr_cmd, wr_lerr, wr_ci;
  assign wr_is   = reg_we && (reg_addr == OFS_ISTAT);
  assign wr_ie   = reg_we && (reg_addr == OFS_IEN);
  assign wr_cmd  = reg_we && (reg_addr == OFS_CMD);
  assign wr_lerr = reg_we && (reg_addr == OFS_LERR);
  assign wr_ci   = reg_we && (reg_addr == OFS_CI);

  // Engine enables and running indicators
  logic st_q, fre_q;
  logic cmd_run, frx_run;
  logic [NENG-1:0] eng_en, eng_run;

  assign eng_en  = {fre_q, st_q};
  assign cmd_run = eng_run[0];
  assign frx_run = eng_run[1];

  for (genvar g = 0; g < NENG; g++) begin : g_eng
    stor_run_track #(.DELAY(RUN_DELAY)) u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (eng_en[g]),
      .run_o (eng_run[g])
    );
  end

  // Start/stop ordering checks
  logic new_st, new_fre;
  logic st_rise_bad, fre_fall_bad, cmd_bad, cmd_ok;
  assign new_st       = reg_wdata[CMD_START_BIT];
  assign new_fre      = reg_wdata[CMD_FRXEN_BIT];
  assign st_rise_bad  = new_st && !st_q && (!fre_q || cmd_run);
  assign fre_fall_bad = !new_fre && fre_q && (st_q || cmd_run);
  assign cmd_bad      = wr_cmd && (st_rise_bad || fre_fall_bad);
  assign cmd_ok       = wr_cmd && !cmd_bad;

  logic viol_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= 1'b0;
      fre_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      if (cmd_ok) begin
        st_q  <= new_st;
        fre_q <= new_fre;
      end
      if (cmd_bad) viol_q <= 1'b1;
    end
  end
  assign proto_viol_o = viol_q;

  // Interrupt status and enable
  logic [31:0] is_q, ie_q;
  stor_w1c_reg #(.W(32), .MASK(IRQ_MASK)) u_istat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (wr_is ? reg_wdata : 32'h0),
    .set_i (evt_i),
    .q_o   (is_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     ie_q <= '0;
    else if (wr_ie) ie_q <= reg_wdata & IRQ_MASK;
  end

  // Link error
  logic [31:0] lerr_q;
  stor_w1c_reg #(.W(32), .MASK(LERR_MASK)) u_lerr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (wr_lerr ? reg_wdata : 32'h0),
    .set_i (lerr_set_i),
    .q_o   (lerr_q)
  );

  // Command issue: software sets, completion clears, set wins
  logic [NSLOT-1:0] ci_q, ci_set;
  assign ci_set = wr_ci ? reg_wdata[NSLOT-1:0] : '0;
  always_ff @(posedge clk) begin
    if (!rst_n) ci_q <= '0;
    else        ci_q <= (ci_q & ~ci_done_i) | ci_set;
  end

  // Derived outputs
  assign irq_o         = gie_i && |(is_q & ie_q);
  assign err_sum_o     = f_err_any(is_q);
  assign dev_present_o = f_dev_present(tfd_i, lstat_i);

  // Read mux
  logic [31:0] cmd_view;
  always_comb begin
    cmd_view = '0;
    cmd_view[CMD_START_BIT]  = st_q;
    cmd_view[CMD_FRXEN_BIT]  = fre_q;
    cmd_view[CMD_SLOT_LSB +: 5] = 5'(cur_slot_i);
    cmd_view[CMD_FRXRUN_BIT] = frx_run;
    cmd_view[CMD_CMDRUN_BIT] = cmd_run;
  end

  always_comb begin
    case (reg_addr)
      OFS_ISTAT: reg_rdata = is_q;
      OFS_IEN:   reg_rdata = ie_q;
      OFS_CMD:   reg_rdata = cmd_view;
      OFS_TFD:   reg_rdata = {16'h0, tfd_i};
      OFS_LSTAT: reg_rdata = {20'h0, lstat_i};
      OFS_LERR:  reg_rdata = lerr_q;
      OFS_CI:    reg_rdata = 32'(ci_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/stor_port_regs_chk.sv
module stor_port_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        st_q,
  input logic        fre_q,
  input logic        cmd_run,
  input logic        frx_run,
  input logic [31:0] is_q,
  input logic [31:0] evt_i,
  input logic        wr_is,
  input logic        irq_o,
  input logic        gie_i,
  input logic        proto_viol_o
);
  AST_START_PRECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q) |-> ($past(fre_q) && !$past(cmd_run))); // R7

  AST_FRX_STOP_PRECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fre_q) |-> (!$past(st_q) && !$past(cmd_run))); // R8

  AST_CMD_RUN_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == cmd_run) |=> $stable(cmd_run)); // R6

  AST_FRX_RUN_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (fre_q == frx_run) |=> $stable(frx_run)); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_i); // R4

  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_is && (evt_i == 32'h0)) |=> $stable(is_q)); // R2

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_viol_o |=> proto_viol_o); // R7
endmodule

bind stor_port_regs stor_port_regs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_q         (st_q),
  .fre_q        (fre_q),
  .cmd_run      (cmd_run),
  .frx_run      (frx_run),
  .is_q         (is_q),
  .evt_i        (evt_i),
  .wr_is        (wr_is),
  .irq_o        (irq_o),
  .gie_i        (gie_i),
  .proto_viol_o (proto_viol_o)
);

// File: tb/test_stor_port_regs.sv
`timescale 1ns/1ps
module test_stor_port_regs;
  localparam int D     = 3;
  localparam int NS    = 8;
  localparam int SW    = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [6:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [31:0]   evt_i, lerr_set_i;
  logic [15:0]   tfd_i;
  logic [11:0]   lstat_i;
  logic [SW-1:0] cur_slot_i;
  logic [NS-1:0] ci_done_i;
  logic          gie_i, irq_o, dev_present_o, err_sum_o, proto_viol_o;

  stor_port_regs #(.RUN_DELAY(D), .NSLOT(NS)) i_stor_port_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .evt_i, .lerr_set_i, .tfd_i, .lstat_i, .cur_slot_i, .ci_done_i,
    .gie_i, .irq_o, .dev_present_o, .err_sum_o, .proto_viol_o
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Bench-side reference functions
  localparam logic [31:0] B_IRQ_MASK  = 32'hFDC0_00FF;
  localparam logic [31:0] B_LERR_MASK = 32'h07FF_0F03;

  function automatic logic b_err(input logic [31:0] s);
    return s[30] | s[29] | s[28] | s[27] | s[26] | s[24];
  endfunction

  function automatic logic b_present(input logic [15:0] t, input logic [11:0] l);
    logic ok_link;
    case (l[11:8])
      4'd2, 4'd6, 4'd8: ok_link = 1'b1;
      default:          ok_link = (l[3:0] == 4'd3);
    endcase
    return (t[7] == 1'b0) && (t[3] == 1'b0) && ok_link;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v;
  logic [31:0] m_is, m_ie;

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    evt_i = 0; lerr_set_i = 0; tfd_i = 0; lstat_i = 0;
    cur_slot_i = 0; ci_done_i = 0; gie_i = 0;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rd(7'h10, v); chk("R1 istat", v, 0);
    rd(7'h14, v); chk("R1 ien", v, 0);
    rd(7'h18, v); chk("R1 cmd", v, 0);
    rd(7'h30, v); chk("R1 lerr", v, 0);
    rd(7'h38, v); chk("R1 ci", v, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 viol", proto_viol_o, 0);

    // R14 unmapped and unaligned reads
    tfd_i = 16'hFFFF;
    rd(7'h00, v); chk("R14 ofs00", v, 0);
    rd(7'h3C, v); chk("R14 ofs3C", v, 0);
    rd(7'h21, v); chk("R14 unaligned", v, 0);

    // R5 read-only fields and reserved bits
    cur_slot_i = 3'd5;
    wr(7'h18, 32'hFFFF_FFEE);
    rd(7'h18, v); chk("R5 cmd ro", v, 32'h0000_0500);
    chk("R7 legal write no viol", proto_viol_o, 0);

    // R11 read-only views
    tfd_i = 16'hA5C3; lstat_i = 12'h123;
    wr(7'h20, 32'hFFFF_FFFF);
    wr(7'h28, 32'hFFFF_FFFF);
    rd(7'h20, v); chk("R11 tfd", v, 32'h0000_A5C3);
    rd(7'h28, v); chk("R11 lstat", v, 32'h0000_0123);

    // R7 start without frame-receive enable
    wr(7'h18, 32'h0000_0001);
    rd(7'h18, v); chk("R7 start rejected", v, 32'h0000_0500);
    chk("R7 viol set", proto_viol_o, 1);

    // R6 frame-receive running rises after D edges
    wr(7'h18, 32'h0000_0010);
    idle(D - 1);
    rd(7'h18, v); chk("R6 frx run early", v[14], 0);
    idle(1);
    rd(7'h18, v); chk("R6 frx run on time", v[14], 1);

    // R6 command running rises after D edges
    wr(7'h18, 32'h0000_0011);
    idle(D - 1);
    rd(7'h18, v); chk("R6 cmd run early", v[15], 0);
    idle(1);
    rd(7'h18, v); chk("R5 cmd full view", v, 32'h0000_C511);

    // R8 clearing frame-receive while started
    wr(7'h18, 32'h0000_0001);
    rd(7'h18, v); chk("R8 frx clear rejected", v[4], 1);

    // Stop, then try restart while still running (R7)
    wr(7'h18, 32'h0000_0010);
    wr(7'h18, 32'h0000_0011);
    rd(7'h18, v); chk("R7 restart while running rejected", v[0], 0);
    idle(D - 2);
    rd(7'h18, v); chk("R6 cmd run falls late", v[15], 1);
    idle(1);
    rd(7'h18, v); chk("R6 cmd run fell", v[15], 0);
    chk("R7 viol sticky", proto_viol_o, 1);

    // R8 legal clear after engine stopped
    wr(7'h18, 32'h0000_0000);
    rd(7'h18, v); chk("R8 frx clear accepted", v[4], 0);
    idle(D);
    rd(7'h18, v); chk("R6 frx run fell", v[14], 0);

    // R2 directed: reserved bits, event beats clear
    evt_i = 32'hFFFF_FFFF;
    idle(1); evt_i = 0;
    rd(7'h10, v); chk("R2 mask", v, B_IRQ_MASK);
    evt_i = 32'h0000_0001;
    wr(7'h10, 32'h0000_0001);
    evt_i = 0;
    rd(7'h10, v); chk("R2 event wins", v[0], 1);
    wr(7'h10, 32'hFFFF_FFFF);
    rd(7'h10, v); chk("R2 clear all", v, 0);

    // R3 disabled source still recorded; R9 summary
    gie_i = 1;
    wr(7'h14, 32'h0);
    evt_i = 32'h4000_0000;
    idle(1); evt_i = 0;
    rd(7'h10, v); chk("R3 recorded", v, 32'h4000_0000);
    chk("R4 irq masked", irq_o, 0);
    chk("R9 err summary", err_sum_o, 1);
    wr(7'h10, 32'hFFFF_FFFF);

    // R2/R3/R4/R9 random
    m_is = 0; m_ie = 0;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] e, d;
      int op;
      e  = $urandom & $urandom & $urandom;
      d  = $urandom;
      op = int'($urandom % 4);
      gie_i = ($urandom % 4) != 0;
      evt_i = e;
      if (op == 0) begin
        wr(7'h10, d);
        m_is = ((m_is & ~d) | e) & B_IRQ_MASK;
      end else if (op == 1) begin
        wr(7'h14, d);
        m_ie = d & B_IRQ_MASK;
        m_is = (m_is | e) & B_IRQ_MASK;
      end else begin
        idle(1);
        m_is = (m_is | e) & B_IRQ_MASK;
      end
      evt_i = 0;
      rd(7'h10, v); chk("R2 rand istat", v, m_is);
      rd(7'h14, v); chk("R3 rand ien", v, m_ie);
      chk("R4 rand irq", irq_o, gie_i & ((m_is & m_ie) != 0));
      chk("R9 rand err", err_sum_o, b_err(m_is));
    end

    // R10 random presence
    for (int i = 0; i < 60; i++) begin
      tfd_i   = 16'($urandom) & (($urandom % 2) ? 16'hFF77 : 16'hFFFF);
      lstat_i = 12'($urandom);
      if ($urandom % 3 == 0) lstat_i[3:0] = 4'd3;
      #1;
      chk("R10 present", dev_present_o, b_present(tfd_i, lstat_i));
    end
    tfd_i = 16'h0; lstat_i = 12'h800;
    #1; chk("R10 power state 8", dev_present_o, 1);
    tfd_i = 16'h0008; #1; chk("R10 drq blocks", dev_present_o, 0);
    idle(1);

    // R12 link error
    lerr_set_i = 32'hFFFF_FFFF;
    idle(1); lerr_set_i = 0;
    rd(7'h30, v); chk("R12 mask", v, B_LERR_MASK);
    wr(7'h30, 32'h0000_0003);
    rd(7'h30, v); chk("R12 clear", v, 32'h07FF_0F00);

    // R13 command issue
    wr(7'h38, 32'h0000_0005);
    rd(7'h38, v); chk("R13 set", v, 32'h5);
    wr(7'h38, 32'h0000_0002);
    rd(7'h38, v); chk("R13 accumulate", v, 32'h7);
    wr(7'h38, 32'h0);
    rd(7'h38, v); chk("R13 zero write", v, 32'h7);
    wr(7'h38, 32'hFFFF_FF00);
    rd(7'h38, v); chk("R13 upper bits", v, 32'h7);
    ci_done_i = 8'h04;
    idle(1); ci_done_i = 0;
    rd(7'h38, v); chk("R13 done clears", v, 32'h3);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule